// File: doc/BRIEF.md
# ADC Serial Frame Controller

This block is the digital, peripheral-side half of a serial port for a multichannel sampling converter. The host drives a chip-select line, a frame-sync line, a serial clock and a serial data line. The block finds where each operation cycle starts, counts serial clocks inside the cycle and clocks in a 4-bit command. At the same time it shifts out a 16-bit result word, which it takes from a parallel input at the start of the cycle. The converter core is not part of this block. Channel handling is limited to latching the command and marking whether it names one of eight inputs.

Two kinds of framing are supported. The frame-sync level at the moment chip select falls decides which one applies. If frame sync is high, the chip-select fall starts the cycle, as in SPI. If frame sync is low, the port is armed, and a later frame-sync rising edge starts the cycle, as in DSP-style framing. All four host pins are brought into the block's clock domain through a synchronizer, and their edges are found there. The block also gives a one-cycle strobe on the eleventh counted rising edge for the sampling trigger logic. A separate tick on every serial clock rise can be enabled so that the serial clock can act as a conversion clock, whatever the level of chip select.

Top module: `adc_sif_top`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` is 0, `cycle_active` is 0, and `sclk` or `sdi` activity changes neither `cmd_o`, `cmd_valid` nor `sample_pulse`.
- R2: A falling edge of `cs_n` while `fs` is high starts a cycle: `cycle_active` goes to 1 and `sdo_oe` goes to 1.
- R3: A falling edge of `cs_n` while `fs` is low sets `sdo_oe` to 1 but keeps `cycle_active` at 0, and serial clocks are not counted. The next rising edge of `fs` while `cs_n` stays low starts the cycle.
- R4: `sdi` is sampled on `sclk` rising edges, MSB first. The first four bits form `cmd_o` (the first bit is bit 3). `cmd_valid` is 0 from the start of a cycle until the fourth rise and 1 after it.
- R5: `chan_valid` is 1 when `cmd_valid` is 1 and bit 3 of `cmd_o` is 0 (codes 0 to 7). `chan_o` equals bits 2..0 of `cmd_o`.
- R6: `result_i` is captured at the start of the cycle. `sdo` shows it MSB first: after k falling `sclk` edges of the cycle, `sdo` equals bit 15-k.
- R7: The 16th counted rise ends the cycle. After it, `cycle_active` and `sdo` are 0, and further clocks change nothing until the next framing event.
- R8: `sample_pulse` is high for exactly one clock per full cycle, following the 11th counted rise.
- R9: A framing event during a running cycle aborts the cycle, restarts the count, clears `cmd_valid` and reloads `result_i`.
- R10: When `conv_en` is 1, `conv_tick` pulses once for each `sclk` rising edge, whatever the level of `cs_n`. When `conv_en` is 0, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all host pins are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| fs | input | 1 | Frame sync |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| conv_en | input | 1 | Enables the conversion-clock tick |
| result_i | input | 16 | Parallel result word to shift out |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial-out driver |
| cycle_active | output | 1 | High while an operation cycle runs |
| sample_pulse | output | 1 | One-clock strobe after the 11th counted rise |
| conv_tick | output | 1 | One-clock strobe per serial clock rise when enabled |
| cmd_o | output | 4 | Latched command word |
| cmd_valid | output | 1 | Command word complete for this cycle |
| chan_o | output | 3 | Channel index taken from the command |
| chan_valid | output | 1 | Command selects one of eight inputs |

## Verification
The assertions check on every cycle that a deselected port falls back to idle with its driver off, and that an armed port holds its count at zero. They also check that the counter stays saturated in the hold state, that every framing event leaves a running cycle at count zero, and that the command and sample strobes appear only at their fixed counts. What only the bench can show is the data itself. It sweeps all sixteen command codes, alternating between the two framing styles, each with its own result word. This shows bit order on both data lines, channel decoding, and that the result is sent bit by bit. The bench also shows that clocks after the end of a cycle are ignored, that an aborted cycle is restarted cleanly, and how the conversion tick counts with chip select high or low.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

    localparam int unsigned FRAME_CLKS = 16;
    localparam int unsigned CMD_W      = 4;
    localparam int unsigned RES_W      = 16;
    localparam int unsigned PULSE_AT   = 11;
    localparam int unsigned SYNC_STG   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_HOLD  = 2'd3
    } frame_st_e;

    typedef struct packed {
        logic cs_n;
        logic fs;
        logic sclk;
        logic sdi;
    } pins_t;

    localparam pins_t PINS_RST = '{cs_n: 1'b1, fs: 1'b0, sclk: 1'b0, sdi: 1'b0};

    function automatic logic chan_ok(input logic [CMD_W-1:0] cmd);
        return cmd[CMD_W-1] == 1'b0;
    endfunction

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (STAGES <= 1) begin : g_single
        logic [W-1:0] stg_q;
        always_ff @(posedge clk) begin
            if (rst) stg_q <= RST_VAL;
            else     stg_q <= d;
        end
        assign q = stg_q;
    end else begin : g_chain
        logic [STAGES-1:0][W-1:0] stg_q;
        always_ff @(posedge clk) begin
            if (rst) stg_q <= {STAGES{RST_VAL}};
            else     stg_q <= {stg_q[STAGES-2:0], d};
        end
        assign q = stg_q[STAGES-1];
    end
endmodule

// File: rtl/sif_frame_ctrl.sv
module sif_frame_ctrl
    import adc_sif_pkg::*;
#(
    parameter int unsigned N_CLKS = FRAME_CLKS,
    parameter int unsigned P_AT   = PULSE_AT,
    localparam int unsigned CW    = $clog2(N_CLKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n_s,
    input  logic          fs_s,
    input  logic          sclk_s,
    input  logic          conv_en,
    output logic          start,
    output logic          run_rise,
    output logic          run_fall,
    output logic [CW-1:0] cnt,
    output logic          active,
    output logic          sel,
    output logic          sample_pulse,
    output logic          conv_tick
);
    frame_st_e     st_q;
    logic [CW-1:0] cnt_q;
    logic          cs_prev_q, fs_prev_q, sclk_prev_q;
    logic          sel_q, pulse_q, tick_q;
    logic          cs_fall, fs_rise, sclk_rise, sclk_fall, arm;

    assign cs_fall   = cs_prev_q & ~cs_n_s;
    assign fs_rise   = ~fs_prev_q & fs_s;
    assign sclk_rise = ~sclk_prev_q & sclk_s;
    assign sclk_fall = sclk_prev_q & ~sclk_s;

    // Framing event: chip-select fall with sync high, or sync rise while selected
    assign start    = ~cs_n_s & (cs_fall ? fs_s : fs_rise);
    assign arm      = cs_fall & ~fs_s;
    assign run_rise = (st_q == ST_RUN) & sclk_rise & ~start;
    assign run_fall = (st_q == ST_RUN) & sclk_fall & ~start & (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev_q   <= 1'b1;
            fs_prev_q   <= 1'b0;
            sclk_prev_q <= 1'b0;
            st_q        <= ST_IDLE;
            cnt_q       <= '0;
            sel_q       <= 1'b0;
            pulse_q     <= 1'b0;
            tick_q      <= 1'b0;
        end else begin
            cs_prev_q   <= cs_n_s;
            fs_prev_q   <= fs_s;
            sclk_prev_q <= sclk_s;
            sel_q       <= ~cs_n_s;
            pulse_q     <= run_rise && (cnt_q == CW'(P_AT - 1));
            tick_q      <= conv_en & sclk_rise;
            if (cs_n_s) begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
            end else if (start) begin
                st_q  <= ST_RUN;
                cnt_q <= '0;
            end else if (arm) begin
                st_q  <= ST_ARMED;
                cnt_q <= '0;
            end else if (run_rise) begin
                if (cnt_q == CW'(N_CLKS - 1)) st_q  <= ST_HOLD;
                else                          cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt          = cnt_q;
    assign active       = (st_q == ST_RUN);
    assign sel          = sel_q;
    assign sample_pulse = pulse_q;
    assign conv_tick    = tick_q;

    p_deselect_idle_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (st_q == ST_IDLE && !sel_q));
    p_armed_no_count_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ARMED) |-> (cnt_q == '0));
    p_count_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |-> (cnt_q == CW'(N_CLKS - 1)));
    p_pulse_at_edge_r8: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (st_q == ST_RUN && cnt_q == CW'(P_AT)));
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (st_q == ST_RUN && cnt_q == '0));
endmodule

// File: rtl/sif_shifter.sv
module sif_shifter
    import adc_sif_pkg::*;
#(
    parameter int unsigned CMD_BITS = CMD_W,
    parameter int unsigned RES_BITS = RES_W,
    parameter int unsigned CW       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                run_rise,
    input  logic                run_fall,
    input  logic [CW-1:0]       cnt,
    input  logic                active,
    input  logic                sdi_s,
    input  logic [RES_BITS-1:0] result,
    output logic                sdo,
    output logic [CMD_BITS-1:0] cmd,
    output logic                cmd_valid
);
    logic [CMD_BITS-1:0] cmd_sh_q, cmd_q;
    logic [RES_BITS-1:0] res_sh_q;
    logic                valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_sh_q <= '0;
            cmd_q    <= '0;
            res_sh_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            if (start) begin
                res_sh_q <= result;
                valid_q  <= 1'b0;
            end else begin
                if (run_fall) res_sh_q <= {res_sh_q[RES_BITS-2:0], 1'b0};
                if (run_rise && cnt < CW'(CMD_BITS)) begin
                    cmd_sh_q <= {cmd_sh_q[CMD_BITS-2:0], sdi_s};
                    if (cnt == CW'(CMD_BITS - 1)) begin
                        cmd_q   <= {cmd_sh_q[CMD_BITS-2:0], sdi_s};
                        valid_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign sdo       = active & res_sh_q[RES_BITS-1];
    assign cmd       = cmd_q;
    assign cmd_valid = valid_q;

    p_cmd_done_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> (cnt == CW'(CMD_BITS)));
    p_cmd_stable_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(run_rise) |-> $stable(cmd_q));
endmodule

// File: rtl/adc_sif_top.sv
module adc_sif_top
    import adc_sif_pkg::*;
#(
    parameter int unsigned N_CLKS   = FRAME_CLKS,
    parameter int unsigned CMD_BITS = CMD_W,
    parameter int unsigned RES_BITS = RES_W,
    parameter int unsigned P_AT     = PULSE_AT,
    localparam int unsigned CW      = $clog2(N_CLKS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                fs,
    input  logic                sclk,
    input  logic                sdi,
    input  logic                conv_en,
    input  logic [RES_BITS-1:0] result_i,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                cycle_active,
    output logic                sample_pulse,
    output logic                conv_tick,
    output logic [CMD_BITS-1:0] cmd_o,
    output logic                cmd_valid,
    output logic [CMD_BITS-2:0] chan_o,
    output logic                chan_valid
);
    pins_t         raw, syn;
    logic          start, run_rise, run_fall, active;
    logic [CW-1:0] cnt;

    assign raw = '{cs_n: cs_n, fs: fs, sclk: sclk, sdi: sdi};

    sif_sync #(.W($bits(pins_t)), .STAGES(SYNC_STG), .RST_VAL(PINS_RST)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    sif_frame_ctrl #(.N_CLKS(N_CLKS), .P_AT(P_AT)) u_ctrl (
        .clk(clk), .rst(rst), .cs_n_s(syn.cs_n), .fs_s(syn.fs), .sclk_s(syn.sclk),
        .conv_en(conv_en), .start(start), .run_rise(run_rise), .run_fall(run_fall),
        .cnt(cnt), .active(active), .sel(sdo_oe), .sample_pulse(sample_pulse),
        .conv_tick(conv_tick)
    );

    sif_shifter #(.CMD_BITS(CMD_BITS), .RES_BITS(RES_BITS), .CW(CW)) u_shift (
        .clk(clk), .rst(rst), .start(start), .run_rise(run_rise), .run_fall(run_fall),
        .cnt(cnt), .active(active), .sdi_s(syn.sdi), .result(result_i),
        .sdo(sdo), .cmd(cmd_o), .cmd_valid(cmd_valid)
    );

    assign cycle_active = active;
    assign chan_o       = cmd_o[CMD_BITS-2:0];
    assign chan_valid   = cmd_valid & chan_ok(cmd_o);

    p_chan_needs_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        chan_valid |-> (cmd_valid && !cmd_o[CMD_BITS-1]));
endmodule

// File: tb/tb_adc_sif_top.sv
module tb_adc_sif_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, fs = 1'b0, sclk = 1'b0, sdi = 1'b0, conv_en = 1'b0;
    logic [15:0] result_i = '0;
    logic        sdo, sdo_oe, cycle_active, sample_pulse, conv_tick, cmd_valid, chan_valid;
    logic [3:0]  cmd_o;
    logic [2:0]  chan_o;

    int checks = 0, fails = 0;
    int rises = 0, pulse_cnt = 0, pulse_rise = -1, tick_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_sif_top dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .fs(fs), .sclk(sclk), .sdi(sdi),
        .conv_en(conv_en), .result_i(result_i), .sdo(sdo), .sdo_oe(sdo_oe),
        .cycle_active(cycle_active), .sample_pulse(sample_pulse), .conv_tick(conv_tick),
        .cmd_o(cmd_o), .cmd_valid(cmd_valid), .chan_o(chan_o), .chan_valid(chan_valid)
    );

    always @(posedge clk) begin
        if (sample_pulse) begin
            pulse_cnt  <= pulse_cnt + 1;
            pulse_rise <= rises;
        end
        if (conv_tick) tick_cnt <= tick_cnt + 1;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_sclk(input logic d);
        sdi = d;
        idle(4);
        sclk = 1'b1;
        rises++;
        idle(8);
        sclk = 1'b0;
        idle(8);
    endtask

    // One complete cycle; DSP style reuses a low chip select if already low
    task automatic run_frame(input logic [3:0] cmd, input logic [15:0] res, input bit dsp);
        int p0;
        result_i = res;
        rises = 0;
        p0 = pulse_cnt;
        if (dsp) begin
            if (cs_n) begin
                fs = 1'b0;
                cs_n = 1'b0;
                idle(8);
                chk("R3", "armed oe", 32'(sdo_oe), 1);
                chk("R3", "armed inactive", 32'(cycle_active), 0);
                pulse_sclk(1'b1);
                chk("R3", "armed ignores sclk", 32'(cycle_active), 0);
                rises = 0;
            end
            fs = 1'b1;
            idle(8);
            fs = 1'b0;
            chk("R3", "fs rise starts", 32'(cycle_active), 1);
        end else begin
            fs = 1'b1;
            cs_n = 1'b0;
            idle(8);
            chk("R2", "cs fall starts", 32'(cycle_active), 1);
            chk("R2", "oe on", 32'(sdo_oe), 1);
            fs = 1'b0;
        end
        for (int k = 0; k < 16; k++) begin
            chk("R6", "sdo bit", 32'(sdo), 32'(res[15-k]));
            if (k == 0) chk("R4", "cmd_valid clear at start", 32'(cmd_valid), 0);
            pulse_sclk(k < 4 ? cmd[3-k] : 1'b1);
            if (k == 3) begin
                chk("R4", "cmd_valid", 32'(cmd_valid), 1);
                chk("R4", "cmd value", 32'(cmd_o), 32'(cmd));
                chk("R5", "chan_valid", 32'(chan_valid), 32'(cmd < 4'd8));
                chk("R5", "chan index", 32'(chan_o), 32'(cmd % 8));
            end
        end
        chk("R7", "inactive after 16", 32'(cycle_active), 0);
        chk("R7", "sdo low after 16", 32'(sdo), 0);
        chk("R8", "one pulse", 32'(pulse_cnt - p0), 1);
        chk("R8", "pulse at rise 11", 32'(pulse_rise), 11);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(4);
        chk("R1", "reset oe", 32'(sdo_oe), 0);
        chk("R1", "reset active", 32'(cycle_active), 0);
        chk("R1", "reset cmd_valid", 32'(cmd_valid), 0);
        chk("R1", "reset sdo", 32'(sdo), 0);

        // R1: clocks and data while deselected
        for (int i = 0; i < 5; i++) pulse_sclk(1'b1);
        chk("R1", "deselected oe", 32'(sdo_oe), 0);
        chk("R1", "deselected active", 32'(cycle_active), 0);
        chk("R1", "deselected cmd_valid", 32'(cmd_valid), 0);
        chk("R1", "deselected cmd", 32'(cmd_o), 0);
        chk("R1", "deselected pulse", 32'(pulse_cnt), 0);

        // Sweep every command code, alternating framing style
        for (int c = 0; c < 16; c++) begin
            run_frame(4'(c), 16'((c * 16'h1357) ^ 16'hC3A5), c[0]);
            if (c == 15) begin
                for (int i = 0; i < 3; i++) pulse_sclk(1'b0);
                chk("R7", "hold inactive", 32'(cycle_active), 0);
                chk("R7", "hold sdo", 32'(sdo), 0);
                chk("R7", "hold cmd", 32'(cmd_o), 32'hF);
                chk("R7", "hold no pulse", 32'(pulse_rise), 11);
            end
            cs_n = 1'b1;
            idle(8);
            chk("R1", "oe off after deselect", 32'(sdo_oe), 0);
        end

        // R9: abort mid-cycle with a new sync edge
        cs_n = 1'b0;
        fs = 1'b0;
        idle(8);
        result_i = 16'hFFFF;
        fs = 1'b1;
        idle(8);
        fs = 1'b0;
        for (int i = 0; i < 6; i++) pulse_sclk(1'b1);
        chk("R9", "pre-abort cmd", 32'(cmd_o), 32'hF);
        run_frame(4'h5, 16'h2B6D, 1'b1);
        chk("R9", "restart cmd", 32'(cmd_o), 32'h5);
        cs_n = 1'b1;
        idle(8);

        // R10: conversion tick regardless of chip select
        tick_cnt = 0;
        conv_en = 1'b1;
        for (int i = 0; i < 4; i++) pulse_sclk(1'b0);
        chk("R10", "ticks deselected", 32'(tick_cnt), 4);
        fs = 1'b1;
        cs_n = 1'b0;
        idle(8);
        for (int i = 0; i < 3; i++) pulse_sclk(1'b0);
        chk("R10", "ticks selected", 32'(tick_cnt), 7);
        conv_en = 1'b0;
        for (int i = 0; i < 3; i++) pulse_sclk(1'b0);
        chk("R10", "ticks disabled", 32'(tick_cnt), 7);
        cs_n = 1'b1;
        idle(8);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule